// File: doc/BRIEF.md
# Two-Cell Block Write-Once Flash Code Chain

This block holds two logical bits in a chain of two-cell blocks of multi-level cells. A cell level can only go up, by one step per write. A write strobe names one bit to toggle. The block finds a cell in the current block whose increment toggles that bit. If the current block cannot take that bit, the write goes to the next empty block. When no empty block is left, the block raises a sticky erase request and changes no cell.

Inside a block, the two cells each stand for one bit while the block's total level is low. Once the total reaches Q-1, their roles cross over. The value seen outside is the XOR of all the per-block decodes. The block shows the decoded pair, the status of each block and every cell level, and gives a one-cycle done pulse after each strobe. Q must be odd.

Top module: `fc2_chain`

## Requirements
- R1: After reset, every cell level is 0, `bits_o` is 00, every block reads empty, and `done_o` and `erase_req_o` are low.
- R2: When a block's level sum before a write is below Q-1, a write of bit 1 (`wr_bit_i`=0) raises the left cell and a write of bit 2 (`wr_bit_i`=1) raises the right cell.
- R3: In a block whose left cell is at Q-1 and whose right cell is below Q-1, a bit-1 write raises the right cell. A bit-2 write cannot use that block.
- R4: In a block whose right cell is at Q-1 and whose left cell is below Q-1, a bit-2 write raises the left cell. A bit-1 write cannot use that block.
- R5: When both cells are below Q-1 and their sum is at least Q-1, a bit-1 write raises the right cell and a bit-2 write raises the left cell.
- R6: A block decodes as (bit1, bit2) = (left mod 2, right mod 2) when left+right <= Q-1, and as (right mod 2, left mod 2) otherwise. `bits_o` is the XOR of all block decodes, with bit 1 at `bits_o[0]` and bit 2 at `bits_o[1]`.
- R7: Every accepted write toggles exactly the named bit of `bits_o`.
- R8: `blk_state_o[2b+1:2b]` reports block b: 2'b00 when both cells are 0, 2'b10 when both are Q-1, and 2'b01 otherwise.
- R9: A write that the current block cannot take goes to the next block, which is empty. Blocks are used in ascending index order, and blocks ahead of the current one stay empty.
- R10: A write that needs a new block when the last block is current leaves all cells and `bits_o` unchanged and sets `erase_req_o`. `erase_req_o` stays high and later writes change nothing until reset.
- R11: `done_o` is high for exactly the one cycle after each cycle in which `wr_i` is high.
- R12: `cells_o` holds block b's left cell at bits [2b*LW +: LW] and its right cell at bits [(2b+1)*LW +: LW], with LW = clog2(Q). No level ever decreases or exceeds Q-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one write per high cycle |
| wr_bit_i | input | 1 | Bit to toggle: 0 = bit 1, 1 = bit 2 |
| bits_o | output | 2 | Decoded bit pair |
| blk_state_o | output | 2*M | Per-block status codes |
| cells_o | output | 2*M*LW | All cell levels |
| done_o | output | 1 | One-cycle pulse after each strobe |
| erase_req_o | output | 1 | Sticky chain-exhausted flag |

## Verification
The hardest states to reach are the crossed-over phase and the one-sided states, where a block has a cell pinned at Q-1. Random toggles rarely build those states, and even more rarely do so in the last block at the moment a refused write arrives. Directed runs of the same bit drive a block into the (Q-1, x) and (x, Q-1) states. A long run of a single bit walks through every block and then exhausts the chain. Seeded random runs, each biased toward one bit, mix the crossed-over cases in a natural way. The decoded pair is checked twice: once against the toggle history and once against a decode of the observed cell levels.

// File: rtl/fc2_pkg.sv
package fc2_pkg;
  typedef enum logic [1:0] {
    BLK_EMPTY  = 2'b00,
    BLK_ACTIVE = 2'b01,
    BLK_FULL   = 2'b10
  } blk_state_e;
endpackage

// File: rtl/fc2_cell_pair.sv
module fc2_cell_pair
  import fc2_pkg::*;
#(
  parameter int Q = 5,
  localparam int LW = $clog2(Q)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          bit_i,
  output logic [LW-1:0] left_o,
  output logic [LW-1:0] right_o,
  output logic          wr_ok_o,
  output logic [1:0]    dec_o,
  output blk_state_e    state_o
);
  localparam int SW = LW + 1;
  localparam logic [LW-1:0] TOP = LW'(Q - 1);
  localparam logic [SW-1:0] TOP_S = SW'(Q - 1);

  logic [LW-1:0] l_q, r_q;
  logic [SW-1:0] sum;
  logic          raise_l, raise_r, ok;

  assign sum = {1'b0, l_q} + {1'b0, r_q};

  // cell roles cross once the block sum reaches Q-1
  always_comb begin
    raise_l = 1'b0;
    raise_r = 1'b0;
    ok      = 1'b0;
    if (sum < TOP_S) begin
      ok      = 1'b1;
      raise_l = !bit_i;
      raise_r = bit_i;
    end else if (l_q == TOP && r_q == TOP) begin
      ok = 1'b0;
    end else if (l_q == TOP) begin
      ok      = !bit_i;
      raise_r = !bit_i;
    end else if (r_q == TOP) begin
      ok      = bit_i;
      raise_l = bit_i;
    end else begin
      ok      = 1'b1;
      raise_r = !bit_i;
      raise_l = bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (inc_i && ok) begin
      if (raise_l) l_q <= l_q + 1'b1;
      if (raise_r) r_q <= r_q + 1'b1;
    end
  end

  always_comb begin
    if (sum <= TOP_S) dec_o = {r_q[0], l_q[0]};
    else              dec_o = {l_q[0], r_q[0]};
    if (l_q == '0 && r_q == '0)       state_o = BLK_EMPTY;
    else if (l_q == TOP && r_q == TOP) state_o = BLK_FULL;
    else                               state_o = BLK_ACTIVE;
  end

  assign left_o  = l_q;
  assign right_o = r_q;
  assign wr_ok_o = ok;

  AST_LVL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_q <= TOP && r_q <= TOP); // R12
  AST_LVL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (l_q >= $past(l_q) && r_q >= $past(r_q))); // R12
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ok) |=> ({1'b0, l_q} + {1'b0, r_q} == $past(sum) + 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> ($stable(l_q) && $stable(r_q))); // R10
  AST_FULL_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == BLK_FULL) |-> !wr_ok_o); // R3
endmodule

// File: rtl/fc2_xor_reduce.sv
module fc2_xor_reduce #(
  parameter int M = 4
) (
  input  logic [2*M-1:0] dec_i,
  output logic [1:0]     bits_o
);
  always_comb begin
    bits_o = '0;
    for (int b = 0; b < M; b++) bits_o ^= dec_i[2*b +: 2];
  end
endmodule

// File: rtl/fc2_chain_ctrl.sv
module fc2_chain_ctrl #(
  parameter int M = 4,
  localparam int PW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [M-1:0]  ok_i,
  output logic [M-1:0]  inc_o,
  output logic [PW-1:0] ptr_o,
  output logic          done_o,
  output logic          erase_o
);
  logic [PW-1:0] ptr_q;
  logic          erase_q, done_q, cur_ok, last;

  assign cur_ok = ok_i[ptr_q];
  assign last   = (ptr_q == PW'(M - 1));

  always_comb begin
    inc_o = '0;
    if (wr_i && !erase_q) begin
      if (cur_ok)     inc_o[ptr_q] = 1'b1;
      else if (!last) inc_o[ptr_q + 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      erase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wr_i;
      if (wr_i && !erase_q && !cur_ok) begin
        if (last) erase_q <= 1'b1;
        else      ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign done_o  = done_q;
  assign erase_o = erase_q;

  AST_ERASE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |=> erase_o); // R10
  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> done_o); // R11
  AST_DONE_ONLY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !done_o); // R11
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1)); // R9
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_o)); // R9
endmodule

// File: rtl/fc2_chain.sv
module fc2_chain
  import fc2_pkg::*;
#(
  parameter int Q = 5,
  parameter int M = 4,
  localparam int LW = $clog2(Q)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_bit_i,
  output logic [1:0]        bits_o,
  output logic [2*M-1:0]    blk_state_o,
  output logic [2*M*LW-1:0] cells_o,
  output logic              done_o,
  output logic              erase_req_o
);
  localparam int PW = (M > 1) ? $clog2(M) : 1;

  logic [M-1:0]   ok_vec, inc_vec;
  logic [2*M-1:0] dec_flat;
  logic [PW-1:0]  ptr;

  for (genvar b = 0; b < M; b++) begin : g_blk
    blk_state_e st;
    fc2_cell_pair #(.Q(Q)) u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc_vec[b]),
      .bit_i   (wr_bit_i),
      .left_o  (cells_o[2*b*LW +: LW]),
      .right_o (cells_o[(2*b+1)*LW +: LW]),
      .wr_ok_o (ok_vec[b]),
      .dec_o   (dec_flat[2*b +: 2]),
      .state_o (st)
    );
    assign blk_state_o[2*b +: 2] = st;

    AST_AHEAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (PW'(b) > ptr) |-> (st == BLK_EMPTY)); // R9
  end

  fc2_chain_ctrl #(.M(M)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .ok_i    (ok_vec),
    .inc_o   (inc_vec),
    .ptr_o   (ptr),
    .done_o  (done_o),
    .erase_o (erase_req_o)
  );

  fc2_xor_reduce #(.M(M)) u_xor (
    .dec_i  (dec_flat),
    .bits_o (bits_o)
  );

  AST_EXHAUST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> ($stable(cells_o) && $stable(bits_o))); // R10
endmodule

// File: tb/fc2_chain_bench.sv
module fc2_chain_bench;
  localparam int Q  = 5;
  localparam int M  = 4;
  localparam int LW = $clog2(Q);

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, wr_bit = 1'b0;
  logic [1:0]        bits;
  logic [2*M-1:0]    st;
  logic [2*M*LW-1:0] cells;
  logic              done, erase;

  int n_chk = 0, n_bad = 0;
  int ml[M], mr[M], mptr;
  bit merase;
  logic [1:0] hist;

  always #10 clk = ~clk;

  fc2_chain #(.Q(Q), .M(M)) u_fc2_chain (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_bit_i(wr_bit),
    .bits_o(bits), .blk_state_o(st), .cells_o(cells),
    .done_o(done), .erase_req_o(erase)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit blk_ok(int l, int r, bit b);
    if (l + r < Q - 1) return 1'b1;
    if (l == Q - 1 && r == Q - 1) return 1'b0;
    if (l == Q - 1) return !b;
    if (r == Q - 1) return b;
    return 1'b1;
  endfunction

  task automatic m_apply(int k, bit b);
    if (ml[k] + mr[k] < Q - 1) begin
      if (b) mr[k]++; else ml[k]++;
    end else if (ml[k] == Q - 1) mr[k]++;
    else if (mr[k] == Q - 1) ml[k]++;
    else if (b) ml[k]++;
    else mr[k]++;
    hist[b] = ~hist[b];
  endtask

  task automatic m_write(bit b);
    if (merase) return;
    if (blk_ok(ml[mptr], mr[mptr], b)) m_apply(mptr, b);
    else if (mptr < M - 1) begin
      mptr++;
      m_apply(mptr, b);
    end else merase = 1'b1;
  endtask

  function automatic logic [2*M*LW-1:0] exp_cells();
    logic [2*M*LW-1:0] c = '0;
    for (int b = 0; b < M; b++) begin
      c[2*b*LW +: LW]     = LW'(ml[b]);
      c[(2*b+1)*LW +: LW] = LW'(mr[b]);
    end
    return c;
  endfunction

  function automatic logic [2*M-1:0] exp_state();
    logic [2*M-1:0] s = '0;
    for (int b = 0; b < M; b++) begin
      if (ml[b] == 0 && mr[b] == 0)              s[2*b +: 2] = 2'b00;
      else if (ml[b] == Q - 1 && mr[b] == Q - 1) s[2*b +: 2] = 2'b10;
      else                                       s[2*b +: 2] = 2'b01;
    end
    return s;
  endfunction

  function automatic logic [1:0] dec_obs(logic [2*M*LW-1:0] c);
    logic [1:0] acc = '0;
    for (int b = 0; b < M; b++) begin
      int l = int'(c[2*b*LW +: LW]);
      int r = int'(c[(2*b+1)*LW +: LW]);
      if (l + r <= Q - 1) acc ^= {r[0], l[0]};
      else                acc ^= {l[0], r[0]};
    end
    return acc;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < M; b++) begin ml[b] = 0; mr[b] = 0; end
    mptr = 0; merase = 1'b0; hist = 2'b00;
    @(negedge clk);
    chk("R1 cells", cells, 0);
    chk("R1 bits", bits, 0);
    chk("R1 state", st, 0);
    chk("R1 done", done, 0);
    chk("R1 erase", erase, 0);
  endtask

  task automatic do_write(bit b, string tag);
    @(negedge clk);
    chk("R11 done idle", done, 0);
    wr = 1'b1;
    wr_bit = b;
    @(negedge clk);
    wr = 1'b0;
    m_write(b);
    chk(tag, cells, exp_cells());
    chk("R8 state", st, exp_state());
    chk("R7 bits vs history", bits, hist);
    chk("R6 bits vs decode", bits, dec_obs(cells));
    chk("R10 erase", erase, merase);
    chk("R11 done pulse", done, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2 then R3: bit 1 fills left, then crosses to the right cell
    repeat (Q - 1) do_write(1'b0, "R2 cells");
    do_write(1'b0, "R3 cells");
    do_write(1'b1, "R9 cells");  // bit 2 refused at (Q-1,1): opens block 1

    do_reset();
    repeat (Q - 1) do_write(1'b1, "R2 cells");
    do_write(1'b1, "R4 cells");
    do_write(1'b0, "R9 cells");  // bit 1 refused at (1,Q-1)

    do_reset();
    for (int i = 0; i < Q - 1; i++) do_write(i[0], "R2 cells");
    for (int i = 0; i < 4; i++) do_write(i[0], "R5 cells");

    do_reset();
    // single-bit run through every block, then past the end
    repeat (2 * (Q - 1) * M) do_write(1'b0, "R12 cells");
    do_write(1'b0, "R10 cells");
    do_write(1'b1, "R10 cells");
    do_write(1'b0, "R10 cells");

    for (int run = 0; run < 4; run++) begin
      do_reset();
      for (int i = 0; i < 50; i++)
        do_write(($urandom % 8) < (2 + run * 2) ? 1'b1 : 1'b0, "R12 cells");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule